// File: doc/BRIEF.md
# Register Scoreboard with Operand Bypass

This block is the hazard logic of an in-order decode stage in front of a 32-entry integer register file. It holds one pending-write flag per architectural register. The flag for a register is raised when decode hands an instruction that writes that register to the next stage. The flag drops when the write-back port commits the register. From these flags it picks, for each of the two source operands, one of four things: a constant zero, the register file's combinational read data, a value forwarded from the execute stage, or a value forwarded from the memory-access stage. When none of these can give a correct value, it holds the instruction back.

Each forwarding channel has two flags. The address flag says which register the stage will produce. The data flag says whether that value exists yet. An execute-stage result therefore forwards at once. A load that is still waiting on memory claims its register and stalls the consumer until the data arrives. A second decode instruction that writes a register whose earlier write is still in flight is also held. This keeps one flag per register correct without counters. A flush mask from the pipeline's squash logic drops the flags of instructions that will never reach write-back.

Decode to issue is a valid/ready stream. `iss_valid` is raised only when the instruction is hazard-free. `dec_ready` follows `iss_ready` unless a hazard blocks the transfer. An instruction is issued, and its destination recorded, only in a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low the decode side must hold its instruction, and nothing is recorded. Write-back, flush and the forwarding channels are plain control inputs with no back-pressure.

Top module: `regscore_bypass`

## Requirements
- R1: In a cycle where an instruction issues (`iss_valid` and `iss_ready` high) with `dec_wr_en` high and `dec_rd_addr` not 0, that register is pending from the next cycle on.
- R2: A write-back (`wb_we` high) to a register clears its pending flag from the next cycle on, so a later read of it takes the register file data.
- R3: A source of address 0 with its enable high gives the operand value 0 and never stalls. Register 0 is never pending.
- R4: A source whose register is not pending takes `rf_rsN_data` in the same cycle, with no clock delay. After reset no register is pending.
- R5: For a pending source, an execute channel whose address flag is set, whose address equals the source address and whose data flag is set supplies the operand, even when the memory-access channel also matches.
- R6: For a pending source, an execute channel that matches on address but has its data flag low stalls, even if the memory-access channel has the data. If the execute channel does not match, a memory-access channel that matches with its data flag set supplies the operand.
- R7: A pending source with no usable forward (as in R5 and R6) forces `iss_valid` and `dec_ready` low.
- R8: When an issue sets a register and a write-back clears the same register in one cycle, the register is pending afterwards.
- R9: Each set bit k of `flush_mask` clears the pending flag of register k from the next cycle on. An issue that sets register k in that same cycle wins over the flush.
- R10: An instruction with `dec_wr_en` high and a non-zero `dec_rd_addr` whose register is pending is stalled, unless a write-back to that register happens in the same cycle.
- R11: `iss_valid` equals `dec_valid` and no hazard; `dec_ready` equals `iss_ready` and no hazard. With `iss_ready` low nothing is recorded.
- R12: A source with its enable low never stalls and gives operand value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_ready | output | 1 | Decode may advance |
| dec_rs1_addr | input | 5 | First source register |
| dec_rs1_en | input | 1 | First source is read |
| dec_rs2_addr | input | 5 | Second source register |
| dec_rs2_en | input | 1 | Second source is read |
| dec_wr_en | input | 1 | Instruction writes a register |
| dec_rd_addr | input | 5 | Destination register |
| rf_rs1_data | input | 64 | Register file read data for source 1 |
| rf_rs2_data | input | 64 | Register file read data for source 2 |
| iss_valid | output | 1 | Instruction and operands offered to execute |
| iss_ready | input | 1 | Execute accepts |
| iss_rs1_data | output | 64 | Resolved operand 1 |
| iss_rs2_data | output | 64 | Resolved operand 2 |
| wb_we | input | 1 | Register write-back strobe |
| wb_addr | input | 5 | Register being written back |
| flush_mask | input | 32 | Per-register clear of squashed writers |
| ex_fwd_addr_vld | input | 1 | Execute channel names a register |
| ex_fwd_data_vld | input | 1 | Execute channel value is ready |
| ex_fwd_addr | input | 5 | Execute channel register |
| ex_fwd_data | input | 64 | Execute channel value |
| ma_fwd_addr_vld | input | 1 | Memory-access channel names a register |
| ma_fwd_data_vld | input | 1 | Memory-access channel value is ready |
| ma_fwd_addr | input | 5 | Memory-access channel register |
| ma_fwd_data | input | 64 | Memory-access channel value |

## Verification
Operand values, `iss_valid` and `dec_ready` are combinational from the inputs and the pending flags. They are due in the same cycle as the stimulus, so the bench drives on the falling edge and samples one time unit later. Pending flags change only at the rising edge. The effect of an issue, write-back or flush (R1, R2, R8, R9) shows in the cycle after it, and the bench reads it back through the stall or operand outputs. The reference model's flags are updated right after each rising edge, from the expected issue decision of the cycle before.

// File: rtl/regsb_pkg.sv
package regsb_pkg;
  // Operand source picked by a selector
  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_RF   = 2'd1,
    SEL_EX   = 2'd2,
    SEL_MA   = 2'd3
  } opnd_sel_e;
endpackage

// File: rtl/regsb_pending_table.sv
module regsb_pending_table #(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_addr,
  input  logic            clr_en,
  input  logic [AW-1:0]   clr_addr,
  input  logic [NREG-1:0] flush_mask,
  output logic [NREG-1:0] pending
);
  assign pending[0] = 1'b0;

  for (genvar k = 1; k < NREG; k++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_addr == AW'(k));
    assign hit_clr = (clr_en && (clr_addr == AW'(k))) || flush_mask[k];
    always_ff @(posedge clk) begin
      if (!rst_n)       pending[k] <= 1'b0;
      else if (hit_set) pending[k] <= 1'b1;   // younger writer wins
      else if (hit_clr) pending[k] <= 1'b0;
    end

    // R9: a flushed bit is clear next cycle unless set at once
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_mask[k] && !hit_set) |=> !pending[k]);
  end

  // R1: issue marks the destination
  p_set_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_addr != '0) |=> pending[$past(set_addr)]);
  // R2, R8: write-back clears unless a same-cycle set
  p_wb_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_addr == clr_addr)) |=> !pending[$past(clr_addr)]);
endmodule

// File: rtl/regsb_src_select.sv
module regsb_src_select
  import regsb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  input  logic [NREG-1:0] pending,
  input  logic [XLEN-1:0] rf_data,
  input  logic            ex_avld,
  input  logic            ex_dvld,
  input  logic [AW-1:0]   ex_addr,
  input  logic [XLEN-1:0] ex_data,
  input  logic            ma_avld,
  input  logic            ma_dvld,
  input  logic [AW-1:0]   ma_addr,
  input  logic [XLEN-1:0] ma_data,
  output logic [XLEN-1:0] opnd,
  output logic            stall
);
  opnd_sel_e sel;
  logic needs, is_pend, ex_hit, ma_hit;

  assign needs   = rd_en && (rd_addr != '0);
  assign is_pend = pending[rd_addr];
  assign ex_hit  = ex_avld && (ex_addr == rd_addr);
  assign ma_hit  = ma_avld && (ma_addr == rd_addr);

  always_comb begin
    sel   = SEL_RF;
    stall = 1'b0;
    if (!needs) begin
      sel = SEL_ZERO;
    end else if (is_pend) begin
      if (ex_hit) begin
        if (ex_dvld) sel = SEL_EX;
        else begin sel = SEL_ZERO; stall = 1'b1; end
      end else if (ma_hit && ma_dvld) begin
        sel = SEL_MA;
      end else begin
        sel = SEL_ZERO; stall = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_RF:  opnd = rf_data;
      SEL_EX:  opnd = ex_data;
      SEL_MA:  opnd = ma_data;
      default: opnd = '0;
    endcase
  end

  // R3: register 0 is zero and never stalls
  p_x0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == '0) |-> (opnd == '0 && !stall));
  // R7: a stall needs a pending flag from the table
  p_stall_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (rd_en && pending[rd_addr]));
  // R4: clear register reads the file
  p_clean_reads_rf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (needs && !pending[rd_addr]) |-> (opnd == rf_data));
endmodule

// File: rtl/regscore_bypass.sv
module regscore_bypass #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG),
  localparam int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  output logic            dec_ready,
  input  logic [AW-1:0]   dec_rs1_addr,
  input  logic            dec_rs1_en,
  input  logic [AW-1:0]   dec_rs2_addr,
  input  logic            dec_rs2_en,
  input  logic            dec_wr_en,
  input  logic [AW-1:0]   dec_rd_addr,
  input  logic [XLEN-1:0] rf_rs1_data,
  input  logic [XLEN-1:0] rf_rs2_data,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [XLEN-1:0] iss_rs1_data,
  output logic [XLEN-1:0] iss_rs2_data,
  input  logic            wb_we,
  input  logic [AW-1:0]   wb_addr,
  input  logic [NREG-1:0] flush_mask,
  input  logic            ex_fwd_addr_vld,
  input  logic            ex_fwd_data_vld,
  input  logic [AW-1:0]   ex_fwd_addr,
  input  logic [XLEN-1:0] ex_fwd_data,
  input  logic            ma_fwd_addr_vld,
  input  logic            ma_fwd_data_vld,
  input  logic [AW-1:0]   ma_fwd_addr,
  input  logic [XLEN-1:0] ma_fwd_data
);
  logic [NREG-1:0] pending;
  logic [NSRC-1:0] src_en, src_stall;
  logic [AW-1:0]   src_addr [NSRC];
  logic [XLEN-1:0] src_rf   [NSRC];
  logic [XLEN-1:0] src_opnd [NSRC];
  logic waw, hazard, fire, set_en;

  assign src_en      = {dec_rs2_en, dec_rs1_en};
  assign src_addr[0] = dec_rs1_addr;
  assign src_addr[1] = dec_rs2_addr;
  assign src_rf[0]   = rf_rs1_data;
  assign src_rf[1]   = rf_rs2_data;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    regsb_src_select #(.XLEN(XLEN), .NREG(NREG)) i_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (src_en[s]),
      .rd_addr (src_addr[s]),
      .pending (pending),
      .rf_data (src_rf[s]),
      .ex_avld (ex_fwd_addr_vld),
      .ex_dvld (ex_fwd_data_vld),
      .ex_addr (ex_fwd_addr),
      .ex_data (ex_fwd_data),
      .ma_avld (ma_fwd_addr_vld),
      .ma_dvld (ma_fwd_data_vld),
      .ma_addr (ma_fwd_addr),
      .ma_data (ma_fwd_data),
      .opnd    (src_opnd[s]),
      .stall   (src_stall[s])
    );
  end

  assign iss_rs1_data = src_opnd[0];
  assign iss_rs2_data = src_opnd[1];

  // Second writer to a busy register waits unless it is being retired now
  assign waw    = dec_wr_en && (dec_rd_addr != '0) && pending[dec_rd_addr]
                  && !(wb_we && wb_addr == dec_rd_addr);
  assign hazard = (|src_stall) || waw;
  assign iss_valid = dec_valid && !hazard;
  assign dec_ready = iss_ready && !hazard;
  assign fire      = iss_valid && iss_ready;
  assign set_en    = fire && dec_wr_en;

  regsb_pending_table #(.NREG(NREG)) i_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (set_en),
    .set_addr   (dec_rd_addr),
    .clr_en     (wb_we),
    .clr_addr   (wb_addr),
    .flush_mask (flush_mask),
    .pending    (pending)
  );

  // R11: no transfer while execute refuses
  p_no_record_unready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_wr_en && dec_rd_addr != '0 && !iss_ready
     && !pending[dec_rd_addr] && !flush_mask[dec_rd_addr]) |=> !pending[$past(dec_rd_addr)]);
  // R10: busy destination blocks the stream
  p_waw_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_wr_en && dec_rd_addr != '0 && pending[dec_rd_addr] && !(wb_we && wb_addr == dec_rd_addr))
    |-> (!iss_valid && !dec_ready));
endmodule

// File: tb/test_regscore_bypass.sv
module test_regscore_bypass;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dec_valid, dec_ready, dec_rs1_en, dec_rs2_en, dec_wr_en;
  logic [4:0] dec_rs1_addr, dec_rs2_addr, dec_rd_addr, wb_addr, ex_fwd_addr, ma_fwd_addr;
  logic [63:0] rf_rs1_data, rf_rs2_data, iss_rs1_data, iss_rs2_data, ex_fwd_data, ma_fwd_data;
  logic iss_valid, iss_ready, wb_we;
  logic [31:0] flush_mask;
  logic ex_fwd_addr_vld, ex_fwd_data_vld, ma_fwd_addr_vld, ma_fwd_data_vld;

  int checks = 0, failures = 0;
  logic [31:0] model_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regscore_bypass i_regscore_bypass (.*);

  task automatic chk_bit(input string tag, input string note, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s): actual=%0b expected=%0b", tag, note, act, exp);
    end
  endtask

  task automatic chk_data(input string tag, input string note, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s): actual=%h expected=%h", tag, note, act, exp);
    end
  endtask

  // Expected operand for one source, from the requirements
  function automatic void src_exp(input logic en, input logic [4:0] a, input logic [63:0] rfd,
                                  output logic st, output logic [63:0] d, output string tag);
    st = 1'b0; d = '0;
    if (!en) tag = "R12";
    else if (a == 5'd0) tag = "R3";
    else if (!model_pend[a]) begin tag = "R4"; d = rfd; end
    else if (ex_fwd_addr_vld && ex_fwd_addr == a) begin
      if (ex_fwd_data_vld) begin tag = "R5"; d = ex_fwd_data; end
      else begin tag = "R6"; st = 1'b1; end
    end else if (ma_fwd_addr_vld && ma_fwd_addr == a && ma_fwd_data_vld) begin
      tag = "R6"; d = ma_fwd_data;
    end else begin tag = "R7"; st = 1'b1; end
  endfunction

  task automatic step(input string note);
    logic s1, s2, waw, haz, ev, er, fire;
    logic [63:0] d1, d2;
    string t1, t2, tv;
    logic [31:0] nxt;
    #1;
    src_exp(dec_rs1_en, dec_rs1_addr, rf_rs1_data, s1, d1, t1);
    src_exp(dec_rs2_en, dec_rs2_addr, rf_rs2_data, s2, d2, t2);
    waw = dec_wr_en && dec_rd_addr != 0 && model_pend[dec_rd_addr]
          && !(wb_we && wb_addr == dec_rd_addr);
    haz = s1 || s2 || waw;
    ev = dec_valid && !haz;
    er = iss_ready && !haz;
    tv = waw ? "R10" : ((s1 || s2) ? "R7" : "R11");
    chk_bit(tv, {note, " iss_valid"}, iss_valid, ev);
    chk_bit(tv, {note, " dec_ready"}, dec_ready, er);
    if (!s1) chk_data(t1, {note, " rs1"}, iss_rs1_data, d1);
    if (!s2) chk_data(t2, {note, " rs2"}, iss_rs2_data, d2);
    fire = ev && iss_ready;
    nxt = model_pend;
    for (int r = 1; r < 32; r++) begin
      if (wb_we && wb_addr == r) nxt[r] = 1'b0;
      if (flush_mask[r]) nxt[r] = 1'b0;
      if (fire && dec_wr_en && dec_rd_addr == r) nxt[r] = 1'b1;
    end
    @(posedge clk);
    model_pend = nxt;
    @(negedge clk);
  endtask

  task automatic idle();
    dec_valid = 0; dec_rs1_en = 0; dec_rs2_en = 0; dec_wr_en = 0;
    dec_rs1_addr = 0; dec_rs2_addr = 0; dec_rd_addr = 0;
    rf_rs1_data = 64'h1111; rf_rs2_data = 64'h2222;
    iss_ready = 1; wb_we = 0; wb_addr = 0; flush_mask = '0;
    ex_fwd_addr_vld = 0; ex_fwd_data_vld = 0; ex_fwd_addr = 0; ex_fwd_data = 64'hE0E0;
    ma_fwd_addr_vld = 0; ma_fwd_data_vld = 0; ma_fwd_addr = 0; ma_fwd_data = 64'hA0A0;
  endtask

  task automatic rd(input logic [4:0] a1, input logic [4:0] a2);
    idle(); dec_valid = 1; dec_rs1_en = 1; dec_rs1_addr = a1; dec_rs2_en = 1; dec_rs2_addr = a2;
  endtask

  task automatic wr(input logic [4:0] d);
    idle(); dec_valid = 1; dec_wr_en = 1; dec_rd_addr = d;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(5, 7);                                        step("R4 reset state reads file");
    rd(0, 0); rf_rs1_data = 64'hDEAD;                step("R3 x0 gives zero");
    wr(5);                                           step("R1 issue sets rd 5");
    rd(5, 7);                                        step("R1 R7 pending 5 stalls");
    rd(5, 7); ex_fwd_addr_vld = 1; ex_fwd_data_vld = 1; ex_fwd_addr = 5;
    ma_fwd_addr_vld = 1; ma_fwd_data_vld = 1; ma_fwd_addr = 5; step("R5 execute wins");
    rd(5, 7); ex_fwd_addr_vld = 1; ex_fwd_addr = 5;
    ma_fwd_addr_vld = 1; ma_fwd_data_vld = 1; ma_fwd_addr = 5; step("R6 load not ready stalls");
    rd(7, 5); ma_fwd_addr_vld = 1; ma_fwd_data_vld = 1; ma_fwd_addr = 5; step("R6 memory forward");
    wr(5); wb_we = 1; wb_addr = 5;                   step("R8 set with clear");
    rd(5, 0);                                        step("R8 still pending");
    idle(); wb_we = 1; wb_addr = 5;                  step("R2 write-back");
    rd(5, 0);                                        step("R2 reads file after clear");
    wr(9);                                           step("R9 issue rd 9");
    idle(); flush_mask[9] = 1'b1;                    step("R9 flush 9");
    rd(9, 9);                                        step("R9 file after flush");
    wr(12);                                          step("R10 first writer");
    wr(12);                                          step("R10 second writer stalls");
    wr(14); iss_ready = 0;                           step("R11 not ready");
    rd(14, 14);                                      step("R11 nothing recorded");
    rd(12, 12); dec_rs1_en = 0; dec_rs2_en = 0;      step("R12 disabled source");
    idle(); flush_mask = '1;                         step("R9 flush all");

    for (int n = 0; n < 4000; n++) begin
      idle();
      dec_valid = ($urandom_range(0, 3) != 0);
      dec_rs1_en = $urandom_range(0, 7) != 0; dec_rs2_en = $urandom_range(0, 7) != 0;
      dec_rs1_addr = 5'($urandom_range(0, 7)); dec_rs2_addr = 5'($urandom_range(0, 7));
      dec_wr_en = $urandom_range(0, 1); dec_rd_addr = 5'($urandom_range(0, 7));
      rf_rs1_data = {$urandom, $urandom}; rf_rs2_data = {$urandom, $urandom};
      iss_ready = $urandom_range(0, 4) != 0;
      wb_we = $urandom_range(0, 1); wb_addr = 5'($urandom_range(0, 7));
      if ($urandom_range(0, 19) == 0) flush_mask = 32'($urandom) & 32'hFF;
      ex_fwd_addr_vld = $urandom_range(0, 1); ex_fwd_data_vld = $urandom_range(0, 1);
      ex_fwd_addr = $urandom_range(0, 1) ? dec_rs1_addr : 5'($urandom_range(0, 7));
      ex_fwd_data = {$urandom, $urandom};
      ma_fwd_addr_vld = $urandom_range(0, 1); ma_fwd_data_vld = $urandom_range(0, 3) != 0;
      ma_fwd_addr = $urandom_range(0, 1) ? dec_rs2_addr : 5'($urandom_range(0, 7));
      ma_fwd_data = {$urandom, $urandom};
      step("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule